// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar in eight byte-wide BCD registers: seconds, minutes, hours, day of week, date, month, year and century. A timing enable `tick_i` drives it, and `TICK_DIV` pulses of that enable make one second. The default of 2 lets the prescaler be tested; set it to 1 for a plain 1 Hz pulse. The hours register holds either a 24-hour count or a 12-hour count with an AM/PM flag. The date wraps at the true end of each month, and February follows the leap rule of the Gregorian calendar, which uses the century register.

A carry ripples upward through a small state machine, one register per clock cycle. The states are `ST_IDLE` (wait for a second step), `ST_MIN`, `ST_HOUR`, `ST_DAY` (day of week and date step together), `ST_MON`, `ST_YEAR` and `ST_CENT`. The transitions are these:
- `ST_IDLE`→`ST_MIN` when the seconds step wraps 59→00.
- Each later state moves to the next one when its own register wraps.
- Each state falls back to `ST_IDLE` when its register does not wrap, or when the host overwrites that register in the same cycle.
- `ST_CENT` always returns to `ST_IDLE`.

A host write port loads any register in one cycle. The value is stored exactly as given.

Top module: `cal_clock`

## Requirements
- R1: After reset the registers read sec 0x00, min 0x00, hour 0x00 (24-hour), day of week 0x01, date 0x01, month 0x01, year 0x00, century 0x20.
- R2: Seconds advance by one BCD step once every `TICK_DIV` tick pulses. Seconds 59→00 carries into minutes, and minutes 59→00 carries into hours.
- R3: With hour bit 7 = 0 the hour is a BCD count 00..23. The step 23→00 carries into the day.
- R4: With hour bit 7 = 1 the hour runs in 12-hour form: bit 5 is PM and bits 4:0 hold BCD 01..12. The sequence is 12, 01 … 11. PM toggles on 11→12, and the step from 11 PM to 12 AM carries into the day.
- R5: Day of week counts 1..7, advances on every day carry, and wraps 7→1.
- R6: April, June, September and November end at day 30. The other months, February excepted, end at day 31. The date then wraps to 01 and the month advances.
- R7: February has 29 days when the year is a nonzero multiple of 4, or when the year is 00 and the century is a multiple of 4. Otherwise it has 28 days.
- R8: Month 12→01 carries into the year, year 99→00 carries into the century, and the century wraps 99→00.
- R9: A write with `wr_sel_i` = 0..7 loads sec, min, hour, day of week, date, month, year or century with `wr_data_i`. The new value is visible after the next clock edge.
- R10: A write to a register beats a step of that register in the same cycle. The carry chain stops there, and higher registers are left unchanged.
- R11: Writing the seconds register restarts the prescaler. A tick in the write cycle is not counted, and the next second needs `TICK_DIV` fresh pulses.
- R12: A carry moves one register per clock. The minute changes one cycle after the seconds wrap, and each further register follows one cycle after the one below. Tick pulses must be at least 8 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timing enable; `TICK_DIV` pulses make one second |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Register select for a write (0 sec … 7 century) |
| wr_data_i | input | 8 | Write value, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours; bit 7 mode, bit 5 PM in 12-hour mode |
| dow_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | Date, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00..99, BCD |
| cent_o | output | 8 | Century, BCD |

## Verification
Two things can land on the same register in one cycle: a host write and a counting step. This happens on the seconds register when the write comes with the tick pulse that completes a second. It happens on the minute register when the write arrives in the cycle the ripple state machine sits in `ST_MIN`. The bench drives both collisions on exact cycles. It then checks three results: the written value wins, the hour stays untouched, and the seconds prescaler ignores the colliding pulse. Constrained-random calendar loads near month, year and midnight boundaries are compared against a decimal reference model in the bench.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NUM_REGS = 8;

    typedef enum logic [2:0] {
        RS_SEC  = 3'd0,
        RS_MIN  = 3'd1,
        RS_HOUR = 3'd2,
        RS_DOW  = 3'd3,
        RS_DATE = 3'd4,
        RS_MON  = 3'd5,
        RS_YEAR = 3'd6,
        RS_CENT = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MON,
        ST_YEAR,
        ST_CENT
    } ripple_st_e;

    typedef struct packed {
        logic [7:0] val;
        logic       carry;
    } hour_step_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic leap_year(input logic [7:0] yr, input logic [7:0] cen);
        logic [6:0] yb;
        logic [6:0] cb;
        yb = bcd_to_bin(yr);
        cb = bcd_to_bin(cen);
        if (yb == 7'd0) return (cb[1:0] == 2'd0);
        return (yb[1:0] == 2'd0);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon,
                                              input logic [7:0] yr,
                                              input logic [7:0] cen);
        case (mon)
            8'h02:                      return leap_year(yr, cen) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic hour_step_t hour_next(input logic [7:0] h);
        hour_step_t r;
        logic [7:0] hb;
        logic [7:0] inc;
        r.carry = 1'b0;
        if (h[7]) begin
            hb  = {3'b000, h[4:0]};
            inc = bcd_inc(hb);
            if (hb == 8'h12)      r.val = {1'b1, 1'b0, h[5], 5'h01};
            else if (hb == 8'h11) begin
                r.val   = {1'b1, 1'b0, ~h[5], 5'h12};
                r.carry = h[5];
            end
            else                  r.val = {1'b1, 1'b0, h[5], inc[4:0]};
        end else begin
            if (h == 8'h23) begin
                r.val   = 8'h00;
                r.carry = 1'b1;
            end
            else r.val = bcd_inc(h);
        end
        return r;
    endfunction

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            3, 4, 5: return 8'h01;
            7:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
    parameter int TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic sec_step_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last    = (cnt == LAST);
    assign sec_step_o = tick_i && at_last && !restart_i;

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (restart_i) cnt <= '0;
        else if (tick_i)    cnt <= at_last ? '0 : cnt + CW'(1);
    end

    // R11: a seconds write clears the prescale count
    p_prescale_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt == '0));

    // R2: the count never passes its limit
    p_prescale_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/cal_ripple_fsm.sv
module cal_ripple_fsm
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_step_i,
    input  logic       sec_wrap_i,
    input  logic       min_wrap_i,
    input  logic       hour_wrap_i,
    input  logic       date_wrap_i,
    input  logic       mon_wrap_i,
    input  logic       year_wrap_i,
    input  logic [7:0] hit_i,
    output logic [7:0] step_o
);
    ripple_st_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: if (sec_step_i && !hit_i[RS_SEC] && sec_wrap_i) state_nx = ST_MIN;
            ST_MIN:  if (!hit_i[RS_MIN] && min_wrap_i)               state_nx = ST_HOUR;
            ST_HOUR: if (!hit_i[RS_HOUR] && hour_wrap_i)             state_nx = ST_DAY;
            ST_DAY:  if (!hit_i[RS_DATE] && date_wrap_i)             state_nx = ST_MON;
            ST_MON:  if (!hit_i[RS_MON] && mon_wrap_i)               state_nx = ST_YEAR;
            ST_YEAR: if (!hit_i[RS_YEAR] && year_wrap_i)             state_nx = ST_CENT;
            ST_CENT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        step_o = '0;
        unique case (state)
            ST_IDLE: step_o[RS_SEC]  = sec_step_i && !hit_i[RS_SEC];
            ST_MIN:  step_o[RS_MIN]  = !hit_i[RS_MIN];
            ST_HOUR: step_o[RS_HOUR] = !hit_i[RS_HOUR];
            ST_DAY: begin
                step_o[RS_DOW]  = !hit_i[RS_DOW];
                step_o[RS_DATE] = !hit_i[RS_DATE];
            end
            ST_MON:  step_o[RS_MON]  = !hit_i[RS_MON];
            ST_YEAR: step_o[RS_YEAR] = !hit_i[RS_YEAR];
            ST_CENT: step_o[RS_CENT] = !hit_i[RS_CENT];
            default: step_o = '0;
        endcase
    end

    // R8: the century step always ends the chain
    p_chain_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CENT) |=> (state == ST_IDLE));

    // R10: a minute write during the minute step stops the chain
    p_write_stops_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MIN && hit_i[RS_MIN]) |=> (state == ST_IDLE));

    // R12: the ripple touches one register (or the day pair) per cycle
    p_single_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_o[7:4], step_o[2:0]}));

endmodule

// File: rtl/cal_regs.sv
module cal_regs
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] step_i,
    output logic [7:0] hit_o,
    output logic       sec_wrap_o,
    output logic       min_wrap_o,
    output logic       hour_wrap_o,
    output logic       date_wrap_o,
    output logic       mon_wrap_o,
    output logic       year_wrap_o,
    output logic [7:0] val_o [NUM_REGS]
);
    logic [7:0] r       [NUM_REGS];
    logic [7:0] step_val[NUM_REGS];
    hour_step_t hstep;
    logic [7:0] last_day;

    assign hstep       = hour_next(r[RS_HOUR]);
    assign last_day    = month_days(r[RS_MON], r[RS_YEAR], r[RS_CENT]);
    assign sec_wrap_o  = (r[RS_SEC]  == 8'h59);
    assign min_wrap_o  = (r[RS_MIN]  == 8'h59);
    assign hour_wrap_o = hstep.carry;
    assign date_wrap_o = (r[RS_DATE] == last_day);
    assign mon_wrap_o  = (r[RS_MON]  == 8'h12);
    assign year_wrap_o = (r[RS_YEAR] == 8'h99);

    always_comb begin
        step_val[RS_SEC]  = sec_wrap_o  ? 8'h00 : bcd_inc(r[RS_SEC]);
        step_val[RS_MIN]  = min_wrap_o  ? 8'h00 : bcd_inc(r[RS_MIN]);
        step_val[RS_HOUR] = hstep.val;
        step_val[RS_DOW]  = (r[RS_DOW] == 8'h07) ? 8'h01 : bcd_inc(r[RS_DOW]);
        step_val[RS_DATE] = date_wrap_o ? 8'h01 : bcd_inc(r[RS_DATE]);
        step_val[RS_MON]  = mon_wrap_o  ? 8'h01 : bcd_inc(r[RS_MON]);
        step_val[RS_YEAR] = year_wrap_o ? 8'h00 : bcd_inc(r[RS_YEAR]);
        step_val[RS_CENT] = (r[RS_CENT] == 8'h99) ? 8'h00 : bcd_inc(r[RS_CENT]);
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign hit_o[i] = wr_en_i && (wr_sel_i == 3'(i));
        assign val_o[i] = r[i];

        always_ff @(posedge clk) begin
            if (!rst_n)         r[i] <= reset_value(i);
            else if (hit_o[i])  r[i] <= wr_data_i;
            else if (step_i[i]) r[i] <= step_val[i];
        end

        // R9: a write lands in its register on the next edge
        p_write_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o[i] |=> (r[i] == $past(wr_data_i)));
    end

    // R2: seconds wrap to zero
    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i[RS_SEC] && r[RS_SEC] == 8'h59) |=> (r[RS_SEC] == 8'h00));

    // R3: 24-hour count wraps at 23
    p_hour24_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i[RS_HOUR] && r[RS_HOUR] == 8'h23) |=> (r[RS_HOUR] == 8'h00));

    // R4: PM flips on the 11 to 12 step
    p_pm_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i[RS_HOUR] && r[RS_HOUR][7] && r[RS_HOUR][4:0] == 5'h11)
        |=> (r[RS_HOUR][5] != $past(r[RS_HOUR][5])));

    // R5: day of week wraps from 7 to 1
    p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i[RS_DOW] && r[RS_DOW] == 8'h07) |=> (r[RS_DOW] == 8'h01));

endmodule

// File: rtl/cal_clock.sv
module cal_clock #(
    parameter int TICK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o
);
    import cal_pkg::*;

    logic       sec_step;
    logic [7:0] hit;
    logic [7:0] step;
    logic       sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, year_wrap;
    logic [7:0] vals [NUM_REGS];

    cal_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .restart_i  (hit[RS_SEC]),
        .sec_step_o (sec_step)
    );

    cal_ripple_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_step_i  (sec_step),
        .sec_wrap_i  (sec_wrap),
        .min_wrap_i  (min_wrap),
        .hour_wrap_i (hour_wrap),
        .date_wrap_i (date_wrap),
        .mon_wrap_i  (mon_wrap),
        .year_wrap_i (year_wrap),
        .hit_i       (hit),
        .step_o      (step)
    );

    cal_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .step_i      (step),
        .hit_o       (hit),
        .sec_wrap_o  (sec_wrap),
        .min_wrap_o  (min_wrap),
        .hour_wrap_o (hour_wrap),
        .date_wrap_o (date_wrap),
        .mon_wrap_o  (mon_wrap),
        .year_wrap_o (year_wrap),
        .val_o       (vals)
    );

    assign sec_o  = vals[RS_SEC];
    assign min_o  = vals[RS_MIN];
    assign hour_o = vals[RS_HOUR];
    assign dow_o  = vals[RS_DOW];
    assign date_o = vals[RS_DATE];
    assign mon_o  = vals[RS_MON];
    assign year_o = vals[RS_YEAR];
    assign cent_o = vals[RS_CENT];

    // R1: registers hold their reset values in the first cycle after reset
    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sec_o == 8'h00 && dow_o == 8'h01 && cent_o == 8'h20));

endmodule

// File: tb/sim_cal_clock.sv
module sim_cal_clock;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o, cent_o;

    int nchecks = 0;
    int nfail = 0;

    int m_sec, m_min, m_h24, m_dow, m_date, m_mon, m_year, m_cent;
    bit m_md12;

    always #5 clk = ~clk;

    cal_clock #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o)
    );

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int dim(input int mon, input int yr, input int cen);
        bit leap;
        leap = (yr == 0) ? (cen % 4 == 0) : (yr % 4 == 0);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_hour();
        int h12;
        if (!m_md12) return i2b(m_h24);
        h12 = (m_h24 % 12 == 0) ? 12 : m_h24 % 12;
        return 8'h80 | ((m_h24 >= 12) ? 8'h20 : 8'h00) | i2b(h12);
    endfunction

    task automatic model_second();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_h24++;
                if (m_h24 == 24) begin
                    m_h24 = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > dim(m_mon, m_year, m_cent)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_year++;
                            if (m_year == 100) begin
                                m_year = 0;
                                m_cent = (m_cent + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req,
                       input string what);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(sec_o,  i2b(m_sec),  req, "sec");
        chk(min_o,  i2b(m_min),  req, "min");
        chk(hour_o, exp_hour(),  req, "hour");
        chk(dow_o,  i2b(m_dow),  req, "dow");
        chk(date_o, i2b(m_date), req, "date");
        chk(mon_o,  i2b(m_mon),  req, "mon");
        chk(year_o, i2b(m_year), req, "year");
        chk(cent_o, i2b(m_cent), req, "cent");
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic one_second();
        repeat (DIV) pulse();
        model_second();
    endtask

    task automatic set_time(input int cen, input int yr, input int mon, input int dt,
                            input int dw, input bit md12, input int h24,
                            input int mn, input int sc);
        m_cent = cen; m_year = yr; m_mon = mon; m_date = dt; m_dow = dw;
        m_md12 = md12; m_h24 = h24; m_min = mn; m_sec = sc;
        wr(3'd0, i2b(m_sec));
        wr(3'd1, i2b(m_min));
        wr(3'd2, exp_hour());
        wr(3'd3, i2b(m_dow));
        wr(3'd4, i2b(m_date));
        wr(3'd5, i2b(m_mon));
        wr(3'd6, i2b(m_year));
        wr(3'd7, i2b(m_cent));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        m_sec = 0; m_min = 0; m_h24 = 0; m_md12 = 0; m_dow = 1; m_date = 1;
        m_mon = 1; m_year = 0; m_cent = 20;
        check_all("R1");

        // R9 loads of every register
        set_time(19, 47, 8, 13, 5, 1'b0, 14, 22, 31);
        check_all("R9");
        one_second();
        check_all("R2");

        // R12 ripple timing, one register per cycle
        set_time(20, 10, 3, 3, 2, 1'b0, 5, 10, 59);
        repeat (DIV - 1) pulse();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk(sec_o, 8'h00, "R12", "sec after wrap edge");
        chk(min_o, 8'h10, "R12", "min not yet stepped");
        @(negedge clk);
        chk(min_o, 8'h11, "R12", "min one cycle later");
        model_second();
        repeat (8) @(negedge clk);
        check_all("R12");

        // R10 + R11: seconds write collides with the completing tick
        set_time(20, 10, 3, 3, 2, 1'b0, 5, 10, 12);
        repeat (DIV - 1) pulse();
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h30;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk(sec_o, 8'h30, "R10", "seconds write beats tick");
        repeat (DIV - 1) pulse();
        chk(sec_o, 8'h30, "R11", "prescale restarted");
        pulse();
        chk(sec_o, 8'h31, "R11", "step after full count");

        // R10: minute write while the chain sits on minutes
        set_time(20, 10, 3, 3, 2, 1'b0, 7, 0, 59);
        repeat (DIV - 1) pulse();
        @(negedge clk) tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h59;
        @(negedge clk) wr_en = 1'b0;
        repeat (8) @(negedge clk);
        m_sec = 0; m_min = 59;
        chk(hour_o, 8'h07, "R10", "hour untouched after minute write");
        check_all("R10");

        // R3 24-hour midnight
        set_time(20, 5, 6, 14, 3, 1'b0, 23, 59, 59);
        one_second(); check_all("R3");

        // R4 12-hour sequence
        set_time(20, 5, 6, 14, 3, 1'b1, 11, 59, 59);
        one_second(); check_all("R4");
        chk(hour_o, 8'hB2, "R4", "12 PM encoding");
        set_time(20, 5, 6, 14, 3, 1'b1, 12, 59, 59);
        one_second(); check_all("R4");
        set_time(20, 5, 6, 14, 7, 1'b1, 23, 59, 59);
        one_second(); check_all("R4");
        chk(hour_o, 8'h92, "R4", "12 AM encoding");
        chk(dow_o, 8'h01, "R5", "dow wraps 7 to 1");

        // R6 short months
        set_time(20, 5, 4, 30, 1, 1'b0, 23, 59, 59);
        one_second(); check_all("R6");
        set_time(20, 5, 11, 30, 1, 1'b0, 23, 59, 59);
        one_second(); check_all("R6");
        set_time(20, 5, 7, 30, 1, 1'b0, 23, 59, 59);
        one_second(); check_all("R6");

        // R7 leap rules
        set_time(20, 24, 2, 28, 1, 1'b0, 23, 59, 59);
        one_second(); check_all("R7");
        chk(date_o, 8'h29, "R7", "leap Feb 29");
        set_time(20, 23, 2, 28, 1, 1'b0, 23, 59, 59);
        one_second(); check_all("R7");
        set_time(20, 0, 2, 28, 1, 1'b0, 23, 59, 59);
        one_second(); check_all("R7");
        set_time(21, 0, 2, 28, 1, 1'b0, 23, 59, 59);
        one_second(); check_all("R7");
        chk(mon_o, 8'h03, "R7", "no leap at year 00 century 21");

        // R8 year and century carry
        set_time(20, 99, 12, 31, 4, 1'b0, 23, 59, 59);
        one_second(); check_all("R8");
        set_time(99, 99, 12, 31, 4, 1'b1, 23, 59, 59);
        one_second(); check_all("R8");

        // R2 constrained random
        for (int it = 0; it < 30; it++) begin
            int mon, yr, cen, dt, h, mn, sc, n;
            mon = 1 + int'($urandom % 12);
            yr  = int'($urandom % 100);
            cen = 19 + int'($urandom % 3);
            dt  = dim(mon, yr, cen) - int'($urandom % 2);
            h   = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            mn  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            sc  = 55 + int'($urandom % 5);
            n   = 1 + int'($urandom % 6);
            set_time(cen, yr, mon, dt, 1 + int'($urandom % 7), 1'($urandom % 2),
                     h, mn, sc);
            for (int k = 0; k < n; k++) begin
                one_second();
                check_all("R2");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule